// File: doc/BRIEF.md
# SPI Master Burst Engine

This block runs one SPI master burst from start to finish. Software sets a control word that holds clock polarity and phase, bit order, the sample timing, the chip-select setup and a discard-receive option, and it writes the start bit. At that moment the engine latches a total byte count and a transmit byte count. The first transmit-count bytes come from a TX FIFO and go out on MOSI. Any further bytes up to the total count go out as zero dummy bytes. Each byte shifted in from MISO is pushed into an RX FIFO unless discard is set.

The SCK half-periods come from an external divider as single-cycle `tick` strobes. Each tick that the engine consumes moves SCK by one edge. If the TX FIFO is empty when a data byte is needed, the engine holds SCK at its idle level until data arrives. The start bit reads back as 1 for the whole burst. It clears together with a one-cycle completion pulse once every MISO bit has been sampled and SCK is back at its idle level.

Top module: `spi_burst_engine`

## Requirements
- R1: The control word uses these bits: 0 CPHA, 1 CPOL, 2 CS active level (1 = active high), 5:4 CS line index, 6 manual CS, 7 manual CS level, 8 discard receive, 11 one-tick sample delay, 12 LSB first, 13 normal sampling, 31 start. A write with bit 31 set starts a burst. The read-back word holds the stored fields at the same positions and has bit 31 = 1 exactly while a burst runs.
- R2: Control writes made while a burst runs are ignored. They change no field and start nothing.
- R3: SCK idles at the CPOL level. During a burst it toggles once per consumed tick and gives exactly 16 edges per byte.
- R4: With CPHA=0 each bit is on MOSI before its leading edge. With CPHA=1 each bit is put on MOSI at the leading edge and sampled on the trailing edge. Bits go MSB first unless bit 12 is set. The first transmit-count bytes come from the TX FIFO and the remaining bytes are 0x00.
- R5: MISO is sampled at the sampling edge for normal sampling (bit 13 set). It is sampled one tick later when bits 13 and 11 are both clear, and two ticks later when only bit 11 is set. Each byte is assembled in the same bit order as the transmit side and pushed once.
- R6: When bit 8 is set, no byte is pushed to the RX FIFO.
- R7: The engine pops the TX FIFO only when it is not empty, and it pops exactly min(transmit count, total count) bytes. While it waits for data, SCK stays idle.
- R8: In automatic mode the selected CS line is at its active level for the whole burst and inactive otherwise. Lines that are not selected are always inactive.
- R9: In manual mode the selected CS line outputs the bit 7 level directly.
- R10: When a burst ends, the busy bit clears and `done_o` is high for exactly one cycle.
- R11: A start with a total count of zero raises `done_o` on the next cycle. Busy is never set and no SCK edge is made.
- R12: Both counts are captured at start. Later changes on the count inputs have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read-back with busy in bit 31 |
| burst_len | input | CNT_W | Total bytes in the burst, latched at start |
| tx_len | input | CNT_W | Bytes taken from the TX FIFO, latched at start |
| tick | input | 1 | SCK half-period strobe from the divider |
| tx_empty | input | 1 | TX FIFO empty |
| tx_data | input | 8 | TX FIFO head byte (first-word fall-through) |
| tx_pop | output | 1 | Consume the TX FIFO head byte |
| rx_push | output | 1 | Write `rx_data` into the RX FIFO |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines at their electrical levels |
| done_o | output | 1 | One-cycle burst-complete pulse |

## Verification
The assertions assume that `tick` is the only thing that moves SCK during a burst. They also assume that the RX FIFO can always accept a push, and that `tx_data` is valid whenever `tx_empty` is low. The stimulus generates ticks at random on about one cycle in three and holds `tx_data` at the head of a bench-side queue. It inserts random empty cycles, and sometimes a long forced stall, without ever raising the empty flag falsely while the engine is being fed. MISO is changed only between consumed ticks, so each sample point sees one stable bit.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int BYTE_W         = 8;
    localparam int BIT_IDX_W      = $clog2(BYTE_W);
    localparam int TICKS_PER_BYTE = 2 * BYTE_W;
    localparam int PH_W           = $clog2(TICKS_PER_BYTE);
    localparam int NUM_CS         = 4;
    localparam int CS_SEL_W       = $clog2(NUM_CS);
    localparam int CTL_W          = 32;

    // Control word field positions (software decodes these).
    localparam int POS_CPHA    = 0;
    localparam int POS_CPOL    = 1;
    localparam int POS_CSPOL   = 2;
    localparam int POS_CSSEL   = 4;
    localparam int POS_CSMAN   = 6;
    localparam int POS_CSLVL   = 7;
    localparam int POS_DISCARD = 8;
    localparam int POS_DLY1    = 11;
    localparam int POS_LSB     = 12;
    localparam int POS_NORM    = 13;
    localparam int POS_RUN     = 31;

    typedef struct packed {
        logic                normal_smp;
        logic                lsb_first;
        logic                dly_one;
        logic                discard;
        logic                cs_lvl;
        logic                cs_manual;
        logic [CS_SEL_W-1:0] cs_sel;
        logic                cs_pol;
        logic                cpol;
        logic                cpha;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_SHIFT,
        SEQ_TAIL
    } seq_state_t;

    function automatic xfer_cfg_t decode_cfg(input logic [CTL_W-1:0] w);
        xfer_cfg_t c;
        c.cpha       = w[POS_CPHA];
        c.cpol       = w[POS_CPOL];
        c.cs_pol     = w[POS_CSPOL];
        c.cs_sel     = w[POS_CSSEL +: CS_SEL_W];
        c.cs_manual  = w[POS_CSMAN];
        c.cs_lvl     = w[POS_CSLVL];
        c.discard    = w[POS_DISCARD];
        c.dly_one    = w[POS_DLY1];
        c.lsb_first  = w[POS_LSB];
        c.normal_smp = w[POS_NORM];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] encode_cfg(input xfer_cfg_t c, input logic busy);
        logic [CTL_W-1:0] w;
        w = '0;
        w[POS_CPHA]                = c.cpha;
        w[POS_CPOL]                = c.cpol;
        w[POS_CSPOL]               = c.cs_pol;
        w[POS_CSSEL +: CS_SEL_W]   = c.cs_sel;
        w[POS_CSMAN]               = c.cs_manual;
        w[POS_CSLVL]               = c.cs_lvl;
        w[POS_DISCARD]             = c.discard;
        w[POS_DLY1]                = c.dly_one;
        w[POS_LSB]                 = c.lsb_first;
        w[POS_NORM]                = c.normal_smp;
        w[POS_RUN]                 = busy;
        return w;
    endfunction

    // Ticks from burst start to the first MISO sample point.
    function automatic logic [1:0] sample_offset(input xfer_cfg_t c);
        logic [1:0] d;
        if (c.normal_smp)   d = 2'd0;
        else if (c.dly_one) d = 2'd2;
        else                d = 2'd1;
        return d + {1'b0, c.cpha};
    endfunction

    function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                      input logic [BIT_IDX_W-1:0] i,
                                      input logic lsb);
        return lsb ? b[i] : b[BIT_IDX_W'(BYTE_W-1) - i];
    endfunction

endpackage

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl import spi_burst_pkg::*; (
    input  logic                busy,
    input  logic                cs_pol,
    input  logic                cs_manual,
    input  logic                cs_lvl,
    input  logic [CS_SEL_W-1:0] cs_sel,
    output logic [NUM_CS-1:0]   cs_lines
);

    for (genvar k = 0; k < NUM_CS; k++) begin : g_line
        always_comb begin
            if (cs_sel != CS_SEL_W'(k))
                cs_lines[k] = ~cs_pol;
            else if (cs_manual)
                cs_lines[k] = cs_lvl;
            else
                cs_lines[k] = busy ? cs_pol : ~cs_pol;
        end
    end

    always_comb begin
        AST_CS_SINGLE_ACTIVE: assert ($countones(cs_lines ^ {NUM_CS{~cs_pol}}) <= 1); // R8
    end

endmodule

// File: rtl/spi_tx_seq.sv
module spi_tx_seq import spi_burst_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              stop,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              lsb_first,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              sck,
    output logic              mosi,
    output logic              edge_ev,
    output logic              tx_fin
);

    seq_state_t        st;
    logic [CNT_W-1:0]  idx, nbytes, ntx;
    logic [CNT_W-1:0]  idx_nx;
    logic [PH_W-1:0]   ph;
    logic [BYTE_W-1:0] txb, load_byte;
    logic              sck_q, mosi_q, need_fifo, load_ok;

    assign need_fifo = (idx < ntx);
    assign load_ok   = !need_fifo || !tx_empty;
    assign load_byte = need_fifo ? tx_data : '0;
    assign idx_nx    = idx + 1'b1;
    assign tx_pop    = (st == SEQ_LOAD) && need_fifo && !tx_empty;
    assign edge_ev   = tick && ((st == SEQ_SHIFT) || (st == SEQ_TAIL));
    assign tx_fin    = (st == SEQ_TAIL);
    assign sck       = (st == SEQ_SHIFT) ? sck_q : cpol;
    assign mosi      = mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SEQ_IDLE;
            idx    <= '0;
            nbytes <= '0;
            ntx    <= '0;
            ph     <= '0;
            txb    <= '0;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
        end else if (go) begin
            st     <= SEQ_LOAD;
            idx    <= '0;
            nbytes <= burst_len;
            ntx    <= tx_len;
        end else if (stop) begin
            st     <= SEQ_IDLE;
            mosi_q <= 1'b0;
        end else begin
            case (st)
                SEQ_LOAD: begin
                    if (load_ok) begin
                        txb   <= load_byte;
                        ph    <= '0;
                        sck_q <= cpol;
                        if (!cpha)
                            mosi_q <= pick_bit(load_byte, '0, lsb_first);
                        st <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (tick) begin
                        sck_q <= ~sck_q;
                        ph    <= ph + 1'b1;
                        if (!cpha && ph[0] && (ph != PH_W'(TICKS_PER_BYTE-1)))
                            mosi_q <= pick_bit(txb, ph[PH_W-1:1] + 1'b1, lsb_first);
                        if (cpha && !ph[0])
                            mosi_q <= pick_bit(txb, ph[PH_W-1:1], lsb_first);
                        if (ph == PH_W'(TICKS_PER_BYTE-1)) begin
                            idx <= idx_nx;
                            st  <= (idx_nx == nbytes) ? SEQ_TAIL : SEQ_LOAD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SCK_MOVES_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (st != SEQ_IDLE && !tick && !stop) |=> $stable(sck)); // R3

endmodule

// File: rtl/spi_rx_cap.sv
module spi_rx_cap import spi_burst_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [1:0]        go_off,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              lsb_first,
    input  logic              discard,
    input  logic              ev,
    input  logic              miso,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_all
);

    localparam int LEFT_W = CNT_W + BIT_IDX_W;

    logic [LEFT_W-1:0]    left;
    logic [1:0]           lead;
    logic                 par;
    logic [BIT_IDX_W-1:0] bitc;
    logic [BYTE_W-1:0]    sh, next_sh;

    assign next_sh = lsb_first ? {miso, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], miso};
    assign rx_all  = (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left    <= '0;
            lead    <= '0;
            par     <= 1'b0;
            bitc    <= '0;
            sh      <= '0;
            rx_data <= '0;
            rx_push <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            if (go) begin
                lead <= go_off;
                par  <= 1'b0;
                bitc <= '0;
                left <= {burst_len, {BIT_IDX_W{1'b0}}};
            end else if (ev && !rx_all) begin
                if (lead != 2'd0) begin
                    lead <= lead - 1'b1;
                end else begin
                    par <= ~par;
                    if (!par) begin
                        sh   <= next_sh;
                        bitc <= bitc + 1'b1;
                        left <= left - 1'b1;
                        if (bitc == BIT_IDX_W'(BYTE_W-1)) begin
                            rx_data <= next_sh;
                            rx_push <= !discard;
                        end
                    end
                end
            end
        end
    end

    AST_PUSH_SPACED: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !rx_push); // R5

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine import spi_burst_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_o,
    output logic              done_o
);

    xfer_cfg_t  cfg_q, w_cfg;
    logic       busy_q, done_q;
    logic       accept, start, go, zero_go, fin;
    logic       tx_fin, rx_all, edge_ev;
    logic [1:0] go_off;

    assign w_cfg   = decode_cfg(ctl_wdata);
    assign go_off  = sample_offset(w_cfg);
    assign accept  = ctl_we && !busy_q;
    assign start   = accept && ctl_wdata[POS_RUN];
    assign go      = start && (burst_len != '0);
    assign zero_go = start && (burst_len == '0);
    assign fin     = busy_q && tx_fin && rx_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (accept)
                cfg_q <= w_cfg;
            if (go)
                busy_q <= 1'b1;
            else if (fin)
                busy_q <= 1'b0;
            done_q <= fin || zero_go;
        end
    end

    assign ctl_rdata = encode_cfg(cfg_q, busy_q);
    assign done_o    = done_q;

    spi_tx_seq #(.CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .stop      (fin),
        .cpha      (cfg_q.cpha),
        .cpol      (cfg_q.cpol),
        .lsb_first (cfg_q.lsb_first),
        .burst_len (burst_len),
        .tx_len    (tx_len),
        .tick      (tick),
        .tx_empty  (tx_empty),
        .tx_data   (tx_data),
        .tx_pop    (tx_pop),
        .sck       (sck),
        .mosi      (mosi),
        .edge_ev   (edge_ev),
        .tx_fin    (tx_fin)
    );

    spi_rx_cap #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .go_off    (go_off),
        .burst_len (burst_len),
        .lsb_first (cfg_q.lsb_first),
        .discard   (cfg_q.discard),
        .ev        (edge_ev),
        .miso      (miso),
        .rx_push   (rx_push),
        .rx_data   (rx_data),
        .rx_all    (rx_all)
    );

    spi_cs_ctrl u_cs (
        .busy      (busy_q),
        .cs_pol    (cfg_q.cs_pol),
        .cs_manual (cfg_q.cs_manual),
        .cs_lvl    (cfg_q.cs_lvl),
        .cs_sel    (cfg_q.cs_sel),
        .cs_lines  (cs_o)
    );

    AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (sck == cfg_q.cpol)); // R3
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_o); // R10
    AST_AUTO_CS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !cfg_q.cs_manual) |-> (cs_o[cfg_q.cs_sel] == cfg_q.cs_pol)); // R8
    AST_NO_POP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !tx_pop); // R7

endmodule

// File: tb/sim_spi_burst_engine.sv
`timescale 1ns/1ps
module sim_spi_burst_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [31:0] ctl_wdata;
    logic [31:0] ctl_rdata;
    logic [23:0] burst_len, tx_len;
    logic        tick, tx_empty, miso;
    logic [7:0]  tx_data;
    logic        tx_pop, rx_push, sck, mosi, done_o;
    logic [7:0]  rx_data;
    logic [3:0]  cs_o;

    int checks = 0;
    int failures = 0;

    // Current configuration fields.
    logic       b_cpha, b_cpol, b_cspol, b_man, b_lvl, b_disc, b_lsb;
    logic [1:0] b_sel;
    int         b_smp; // 0 normal, 1 half-cycle delay, 2 one-cycle delay

    logic [7:0] txq   [0:15];
    logic [7:0] rxexp [0:15];
    logic [7:0] txgot [0:15];
    logic [7:0] got   [0:15];

    always #2 clk = ~clk;

    spi_burst_engine u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .burst_len(burst_len), .tx_len(tx_len),
        .tick(tick), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_o(cs_o), .done_o(done_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_word();
        logic [31:0] w;
        w = 32'h0;
        w[0] = b_cpha; w[1] = b_cpol; w[2] = b_cspol; w[5:4] = b_sel;
        w[6] = b_man; w[7] = b_lvl; w[8] = b_disc; w[12] = b_lsb;
        if (b_smp == 0) w[13] = 1'b1;
        if (b_smp == 2) w[11] = 1'b1;
        return w;
    endfunction

    function automatic logic [3:0] exp_cs(input logic active);
        logic [3:0] v;
        for (int k = 0; k < 4; k++) begin
            if (k != int'(b_sel)) v[k] = ~b_cspol;
            else if (b_man)       v[k] = b_lvl;
            else                  v[k] = active ? b_cspol : ~b_cspol;
        end
        return v;
    endfunction

    function automatic logic stream_bit(input int k, input int n);
        int j, i;
        if (k >= 8 * n) return 1'b0;
        j = k / 8;
        i = k % 8;
        return b_lsb ? rxexp[j][i] : rxexp[j][7 - i];
    endfunction

    task automatic write_ctl(input logic [31:0] w);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic random_cfg();
        b_cpha  = 1'($urandom % 2);
        b_cpol  = 1'($urandom % 2);
        b_cspol = 1'($urandom % 2);
        b_sel   = 2'($urandom % 4);
        b_man   = (($urandom % 5) == 0);
        b_lvl   = 1'($urandom % 2);
        b_disc  = (($urandom % 5) == 0);
        b_lsb   = 1'($urandom % 2);
        b_smp   = int'($urandom % 3);
    endtask

    // One burst of n bytes, ntx of them from the FIFO.
    task automatic run_burst(input int n, input int ntx, input int hold, input logic poke);
        int off, edges, t, rd, gotn, donen;
        logic tk, stall, pre_sck, pre_mosi, pre_busy, cs_done, stall_bad, fin_seen;
        logic [31:0] w;
        off = int'(b_cpha) + ((b_smp == 0) ? 0 : (b_smp == 1) ? 1 : 2);
        edges = 0; t = 0; rd = 0; gotn = 0; donen = 0;
        cs_done = 1'b0; stall_bad = 1'b0; fin_seen = 1'b0;
        for (int j = 0; j < 16; j++) begin
            txq[j] = 8'($urandom); rxexp[j] = 8'($urandom);
            txgot[j] = 8'h00; got[j] = 8'h00;
        end
        w = cfg_word();
        burst_len = 24'(n);
        tx_len = 24'(ntx);
        tx_data = txq[0];
        tx_empty = (ntx == 0);
        miso = (off == 0) ? stream_bit(0, n) : 1'b0;
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = w | 32'h8000_0000;
        @(posedge clk);
        // R12: count inputs change after the start; the burst must not notice.
        #1 burst_len = 24'($urandom % 9); tx_len = 24'($urandom % 9);
        for (int cyc = 0; cyc < 6000 && !fin_seen; cyc++) begin
            @(negedge clk);
            ctl_we = 1'b0;
            if (cyc == 0)
                chk(ctl_rdata[31] == 1'b1, "R1 busy bit after start", ctl_rdata, 32'h8000_0000 | w);
            if (poke && cyc == 3) begin
                ctl_we = 1'b1;
                ctl_wdata = ~w; // R2: carries bit 31 and flips every field
            end
            tk = (($urandom % 3) == 0);
            stall = (cyc < hold) || (($urandom % 4) == 0);
            tick = tk;
            tx_empty = (rd >= ntx) || stall;
            tx_data = (rd < 16) ? txq[rd] : 8'h00;
            miso = (t >= off) ? stream_bit((t - off) / 2, n) : 1'b0;
            #1;
            pre_sck = sck; pre_mosi = mosi; pre_busy = ctl_rdata[31];
            if (pre_busy && !cs_done) begin
                cs_done = 1'b1;
                chk(cs_o == exp_cs(1'b1), "R8/R9 chip select during burst", 32'(cs_o), 32'(exp_cs(1'b1)));
            end
            if (tx_pop) begin
                if (tx_empty)
                    chk(1'b0, "R7 pop while empty", 32'(tx_pop), 32'h0);
                rd++;
            end
            if (rx_push) begin
                if (gotn < 16) got[gotn] = rx_data;
                gotn++;
            end
            if (done_o) begin
                donen++;
                fin_seen = 1'b1;
            end
            @(posedge clk);
            #1;
            if (tk && pre_busy) begin
                if (sck !== pre_sck) begin
                    if (cyc < hold) stall_bad = 1'b1;
                    if ((edges % 2) == int'(b_cpha) && edges < 16 * n) begin
                        if (b_lsb) txgot[(edges / 2) / 8][(edges / 2) % 8] = pre_mosi;
                        else       txgot[(edges / 2) / 8][7 - (edges / 2) % 8] = pre_mosi;
                    end
                    edges++;
                    t++;
                end else if (edges == 16 * n) begin
                    t++;
                end
            end
        end
        tick = 1'b0;
        ctl_we = 1'b0;
        chk(fin_seen, "R10 completion pulse seen", 32'(donen), 32'h1);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done lasts one cycle", 32'(done_o), 32'h0);
        chk(ctl_rdata[31] == 1'b0, "R10 busy cleared", ctl_rdata, 32'h0);
        chk(ctl_rdata == (w & 32'h0000_39F7), "R1/R2 read-back fields", ctl_rdata, w & 32'h0000_39F7);
        chk(edges == 16 * n, "R3/R12 SCK edge count", 32'(edges), 32'(16 * n));
        chk(sck == b_cpol, "R3 SCK idle level", 32'(sck), 32'(b_cpol));
        chk(!stall_bad, "R7 SCK idle during stall", 32'(stall_bad), 32'h0);
        chk(rd == ((ntx < n) ? ntx : n), "R7 pop count", 32'(rd), 32'((ntx < n) ? ntx : n));
        chk(cs_o == exp_cs(1'b0), "R8/R9 chip select after burst", 32'(cs_o), 32'(exp_cs(1'b0)));
        for (int j = 0; j < n; j++)
            chk(txgot[j] == ((j < ntx) ? txq[j] : 8'h00), "R4 MOSI byte", 32'(txgot[j]),
                32'((j < ntx) ? txq[j] : 8'h00));
        if (b_disc) begin
            chk(gotn == 0, "R6 discard pushes nothing", 32'(gotn), 32'h0);
        end else begin
            chk(gotn == n, "R5 push count", 32'(gotn), 32'(n));
            for (int j = 0; j < n && j < 16; j++)
                chk(got[j] == rxexp[j], "R5 MISO byte", 32'(got[j]), 32'(rxexp[j]));
        end
        repeat (3) @(negedge clk);
        chk(ctl_rdata[31] == 1'b0, "R2 no restart from ignored write", ctl_rdata, 32'h0);
    endtask

    initial begin
        #600000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic s0;
        void'($urandom(32'h5eed_2024));
        rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; burst_len = '0; tx_len = '0;
        tick = 1'b0; tx_empty = 1'b1; tx_data = '0; miso = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ctl_rdata == 32'h0, "R1 reset read-back", ctl_rdata, 32'h0);
        chk(sck == 1'b0 && done_o == 1'b0 && tx_pop == 1'b0 && rx_push == 1'b0,
            "R3 reset outputs", {28'h0, sck, done_o, tx_pop, rx_push}, 32'h0);
        chk(cs_o == 4'hF, "R8 reset chip selects inactive", 32'(cs_o), 32'hF);

        // R9: manual chip select on line 2, active-low polarity setting.
        b_cpha = 0; b_cpol = 0; b_cspol = 0; b_sel = 2'd2; b_man = 1; b_lvl = 1;
        b_disc = 0; b_lsb = 0; b_smp = 0;
        write_ctl(cfg_word());
        chk(cs_o == 4'b1111, "R9 manual level high", 32'(cs_o), 32'hF);
        b_lvl = 0;
        write_ctl(cfg_word());
        chk(cs_o == 4'b1011, "R9 manual level low", 32'(cs_o), 32'hB);

        // R11: zero total count.
        b_man = 0; b_cpol = 1;
        write_ctl(cfg_word());
        s0 = sck;
        burst_len = 24'd0; tx_len = 24'd3;
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = cfg_word() | 32'h8000_0000; tick = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        chk(done_o == 1'b1, "R11 zero count done next cycle", 32'(done_o), 32'h1);
        chk(ctl_rdata[31] == 1'b0, "R11 zero count never busy", ctl_rdata, 32'h0);
        chk(sck == s0 && tx_pop == 1'b0, "R11 no SCK edge", 32'(sck), 32'(s0));
        @(negedge clk);
        tick = 1'b0;
        chk(done_o == 1'b0, "R11 single pulse", 32'(done_o), 32'h0);

        // Directed corners.
        b_cpha = 0; b_cpol = 0; b_lsb = 0; b_smp = 0; b_disc = 0; b_man = 0; b_sel = 2'd1; b_cspol = 1;
        run_burst(1, 1, 0, 1'b0);                 // single byte, mode 0
        b_cpha = 1; b_cpol = 1; b_lsb = 1; b_smp = 2;
        run_burst(3, 1, 0, 1'b0);                 // dummy bytes, two-tick delay, LSB first
        b_smp = 1; b_cpha = 0;
        run_burst(2, 2, 40, 1'b1);                // forced stall plus ignored write
        b_disc = 1;
        run_burst(4, 6, 0, 1'b0);                 // discard, tx count above total
        b_disc = 0; b_man = 1; b_lvl = 0; b_sel = 2'd3;
        run_burst(2, 0, 0, 1'b0);                 // all dummy, manual CS

        for (int r = 0; r < 24; r++) begin
            int n, ntx;
            random_cfg();
            n = 1 + int'($urandom % 6);
            ntx = int'($urandom % (n + 2));
            run_burst(n, ntx, 0, (($urandom % 4) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule